// File: doc/BRIEF.md
# Serial Codec Control Port

This block accepts writes from a microcontroller over a three-wire, write-only serial link: an active-low frame enable, a shift clock and a data line. It assembles an 8-bit control word, commits that word to a holding register when the frame enable returns high, and decodes the held word into the settings for a voice codec's analog paths. The decoded settings are the transmit input selection, two receive routing enables and a receive attenuation step.

The serial lines run asynchronously to the block. Each line passes through a two-stage synchronizer into the system clock domain, and edges are detected there. An active-low power-down input returns the held word to a non-zero default, which selects the first transmit input. The default stays in place until a new frame is committed after power-down has been released. A one-cycle strobe marks every committed write. The attenuation is given both as its raw 3-bit code and as a signed dB figure.

Top module: `sctl_port`

## Requirements
- R1: After reset, the outputs show the default word 0x80: tx_sel = 01 (input A), drv_route = 0, aux_route = 0, atten_code = 000, atten_db = 0.
- R2: On each rising edge of ser_clk while ser_en_n is low, one bit is taken from ser_dat, most significant bit (b7) first. When more than 8 bits arrive in a frame, the last 8 received are the ones kept.
- R3: The shifted word reaches the decoded outputs only on a rising edge of ser_en_n. A frame that is shifted but not yet closed leaves the outputs unchanged.
- R4: While pwr_dn_n is 0, the held word is forced to the default 0x80 and frames are not committed. The default then persists after pwr_dn_n returns to 1, until the next committed frame.
- R5: tx_sel = {b6, b7}, encoded as 00 mute, 01 input A, 10 input B, 11 sum of both inputs.
- R6: drv_route follows b5 (1 = differential drivers take the drive input, 0 = signal ground). aux_route follows b4 (1 = auxiliary output takes the converter output, 0 = signal ground).
- R7: atten_code = {b2, b1, b0}, with b2 as the MSB. atten_db is the 6-bit two's complement value -4 × atten_code, so codes 0 to 7 give 0 to -28 dB.
- R8: Bit b3 has no effect on any output.
- R9: upd_stb is high for exactly one clock cycle for each committed frame and stays low for a frame closed during power-down.
- R10: Shift clock edges that arrive while ser_en_n is high do not change the shifted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn_n | input | 1 | Active-low power-down, synchronous to clk |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_en_n | input | 1 | Active-low frame enable (asynchronous) |
| ser_dat | input | 1 | Serial data (asynchronous) |
| tx_sel | output | 2 | Transmit input select |
| drv_route | output | 1 | Differential driver routing enable |
| aux_route | output | 1 | Auxiliary output routing enable |
| atten_code | output | 3 | Raw attenuation code |
| atten_db | output | 6 | Attenuation in dB, signed |
| upd_stb | output | 1 | One-cycle pulse per committed write |

## Verification
Four properties are checked on every cycle. The held word must stay constant unless the enable rises, and power-down must force the default. The shift register must not move while the enable is high, and the update strobe can never last two cycles. The bench scenarios are the only way to show the field mapping and bit order: MSB-first shifting, keeping the last eight bits of an overlong frame, the dB conversion, that b3 has no effect, and that the default survives power-down release.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
   typedef enum logic [1:0] {
      TX_MUTE = 2'b00,
      TX_IN_A = 2'b01,
      TX_IN_B = 2'b10,
      TX_SUM  = 2'b11
   } tx_sel_e;

   localparam int unsigned CTL_W = 8;
   localparam logic [CTL_W-1:0] CTL_DEFAULT = 8'h80;
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] d_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sctl_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg_q[s] <= RST_VAL;
         end else if (s == 0) begin
            stg_q[s] <= d_async;
         end else begin
            stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign d_sync = stg_q[STAGES-1];
endmodule

// File: rtl/sctl_edge.sv
module sctl_edge #(
   parameter int unsigned W = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] rise
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
endmodule

// File: rtl/sctl_shift.sv
module sctl_shift #(
   parameter int unsigned W         = 8,
   parameter bit          MSB_FIRST = 1'b1,
   parameter logic [W-1:0] DEF_WORD = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pwr_dn_n,
   input  logic         sclk_rise,
   input  logic         en_lvl_n,
   input  logic         en_rise,
   input  logic         dat,
   output logic [W-1:0] ctl_q,
   output logic         upd_stb
);
   logic [W-1:0] sh_q;
   logic [W-1:0] sh_nxt;

   if (MSB_FIRST) begin : g_msb
      assign sh_nxt = {sh_q[W-2:0], dat};
   end else begin : g_lsb
      assign sh_nxt = {dat, sh_q[W-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (sclk_rise && !en_lvl_n) begin
         sh_q <= sh_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q   <= DEF_WORD;
         upd_stb <= 1'b0;
      end else if (!pwr_dn_n) begin
         ctl_q   <= DEF_WORD;
         upd_stb <= 1'b0;
      end else begin
         upd_stb <= en_rise;
         if (en_rise) ctl_q <= sh_q;
      end
   end

   p_hold_no_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_dn_n && !en_rise) |=> $stable(ctl_q))
      else $error("p_hold_no_commit_r3");

   p_pd_default_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_dn_n |=> (ctl_q == DEF_WORD && !upd_stb))
      else $error("p_pd_default_r4");

   p_stb_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb |=> !upd_stb)
      else $error("p_stb_single_r9");

   p_no_shift_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      en_lvl_n |=> $stable(sh_q))
      else $error("p_no_shift_idle_r10");
endmodule

// File: rtl/sctl_decode.sv
module sctl_decode
   import sctl_pkg::*;
#(
   parameter int unsigned W       = 8,
   parameter int unsigned VOL_W   = 3,
   parameter int unsigned STEP_DB = 4,
   parameter int unsigned DB_W    = 6
) (
   input  logic [W-1:0]           word,
   output tx_sel_e                tx_sel,
   output logic                   drv_route,
   output logic                   aux_route,
   output logic [VOL_W-1:0]       atten_code,
   output logic signed [DB_W-1:0] atten_db
);
   localparam int unsigned POS_SW1 = W - 1;
   localparam int unsigned POS_SW2 = W - 2;
   localparam int unsigned POS_SW3 = W - 3;
   localparam int unsigned POS_SW4 = W - 4;
   localparam int unsigned MAX_DB  = ((1 << VOL_W) - 1) * STEP_DB;
   localparam logic [DB_W-1:0] STEP_V = DB_W'(STEP_DB);

   if (W < VOL_W + 5) begin : g_bad_width
      $error("sctl_decode: word too narrow for fields");
   end
   if (MAX_DB > (1 << (DB_W - 1))) begin : g_bad_db
      $error("sctl_decode: DB_W too small for attenuation range");
   end

   logic [DB_W-1:0] mag;

   assign tx_sel     = tx_sel_e'({word[POS_SW2], word[POS_SW1]});
   assign drv_route  = word[POS_SW3];
   assign aux_route  = word[POS_SW4];
   assign atten_code = word[VOL_W-1:0];
   assign mag        = DB_W'(atten_code) * STEP_V;
   assign atten_db   = $signed(-mag);
endmodule

// File: rtl/sctl_port.sv
module sctl_port
   import sctl_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned VOL_W       = 3,
   parameter int unsigned STEP_DB     = 4,
   parameter int unsigned DB_W        = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_dn_n,
   input  logic             ser_clk,
   input  logic             ser_en_n,
   input  logic             ser_dat,
   output logic [1:0]       tx_sel,
   output logic             drv_route,
   output logic             aux_route,
   output logic [VOL_W-1:0] atten_code,
   output logic [DB_W-1:0]  atten_db,
   output logic             upd_stb
);
   localparam int unsigned W = CTL_W;

   logic [2:0]   raw_in;
   logic [2:0]   syn;
   logic [1:0]   rise;
   logic [W-1:0] ctl_word;
   tx_sel_e      tx_sel_dec;
   logic signed [DB_W-1:0] db_dec;

   assign raw_in = {ser_dat, ser_en_n, ser_clk};

   sctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(raw_in), .d_sync(syn));

   sctl_edge #(.W(2), .RST_VAL(2'b10)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(syn[1:0]), .rise(rise));

   sctl_shift #(.W(W), .MSB_FIRST(1'b1), .DEF_WORD(CTL_DEFAULT)) u_shift (
      .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n),
      .sclk_rise(rise[0]), .en_lvl_n(syn[1]), .en_rise(rise[1]),
      .dat(syn[2]), .ctl_q(ctl_word), .upd_stb(upd_stb));

   sctl_decode #(.W(W), .VOL_W(VOL_W), .STEP_DB(STEP_DB), .DB_W(DB_W)) u_dec (
      .word(ctl_word), .tx_sel(tx_sel_dec), .drv_route(drv_route),
      .aux_route(aux_route), .atten_code(atten_code), .atten_db(db_dec));

   assign tx_sel   = tx_sel_dec;
   assign atten_db = db_dec;
endmodule

// File: tb/sctl_port_tb.sv
module sctl_port_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_dn_n = 1'b1;
   logic ser_clk = 1'b0;
   logic ser_en_n = 1'b1;
   logic ser_dat = 1'b0;
   logic [1:0] tx_sel;
   logic drv_route, aux_route, upd_stb;
   logic [2:0] atten_code;
   logic [5:0] atten_db;
   int n_chk = 0;
   int n_bad = 0;
   int stb_cnt = 0;
   bit done = 0;

   always #5 clk = ~clk;

   sctl_port dut_i (
      .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .ser_clk(ser_clk),
      .ser_en_n(ser_en_n), .ser_dat(ser_dat), .tx_sel(tx_sel),
      .drv_route(drv_route), .aux_route(aux_route), .atten_code(atten_code),
      .atten_db(atten_db), .upd_stb(upd_stb));

   always @(negedge clk) if (upd_stb) stb_cnt++;

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic shift_bits(logic [15:0] v, int n);
      for (int i = n - 1; i >= 0; i--) begin
         ser_dat = v[i];
         wait_n(4);
         ser_clk = 1'b1;
         wait_n(4);
         ser_clk = 1'b0;
      end
   endtask

   task automatic write_frame(logic [15:0] v, int n);
      ser_en_n = 1'b0;
      wait_n(4);
      shift_bits(v, n);
      wait_n(4);
      ser_en_n = 1'b1;
      wait_n(8);
   endtask

   task automatic expect_word(string req, logic [7:0] w);
      logic [1:0] e_tx = {w[6], w[7]};
      logic [2:0] e_code = w[2:0];
      int e_db = -4 * int'(e_code);
      n_chk++;
      if (tx_sel !== e_tx || drv_route !== w[5] || aux_route !== w[4] ||
          atten_code !== e_code || int'($signed(atten_db)) != e_db) begin
         n_bad++;
         $display("FAIL %s: got tx=%b drv=%b aux=%b code=%b db=%0d exp tx=%b drv=%b aux=%b code=%b db=%0d",
                  req, tx_sel, drv_route, aux_route, atten_code, $signed(atten_db),
                  e_tx, w[5], w[4], e_code, e_db);
      end
   endtask

   task automatic expect_stb(string req, int exp);
      n_chk++;
      if (stb_cnt != exp) begin
         n_bad++;
         $display("FAIL %s: strobe count %0d exp %0d", req, stb_cnt, exp);
      end
   endtask

   task automatic t_reset();
      wait_n(2);
      expect_word("R1 reset default", 8'h80);
      expect_stb("R9 no strobe at reset", 0);
   endtask

   task automatic t_tx_select();
      write_frame(16'h00, 8);  expect_word("R5 mute", 8'h00);
      write_frame(16'h80, 8);  expect_word("R5 input A", 8'h80);
      write_frame(16'h40, 8);  expect_word("R5 input B", 8'h40);
      write_frame(16'hC0, 8);  expect_word("R5 sum", 8'hC0);
   endtask

   task automatic t_routes();
      write_frame(16'h20, 8);  expect_word("R6 drv route", 8'h20);
      write_frame(16'h10, 8);  expect_word("R6 aux route", 8'h10);
   endtask

   task automatic t_atten();
      for (int c = 0; c < 8; c++) begin
         write_frame(16'(c), 8);
         expect_word("R7 atten code", 8'(c));
      end
   endtask

   task automatic t_unused_bit();
      write_frame(16'h08, 8);  expect_word("R8 b3 ignored", 8'h00);
      write_frame(16'hAD, 8);  expect_word("R8 b3 ignored", 8'hA5);
   endtask

   task automatic t_strobe();
      int base = stb_cnt;
      write_frame(16'h33, 8);
      n_chk++;
      if (stb_cnt != base + 1) begin
         n_bad++;
         $display("FAIL R9: strobes %0d exp %0d", stb_cnt - base, 1);
      end
   endtask

   task automatic t_overlong();
      write_frame(16'hF25, 12);
      expect_word("R2 last eight bits kept", 8'h25);
   endtask

   task automatic t_idle_clocks();
      ser_dat = 1'b1;
      for (int i = 0; i < 5; i++) begin
         wait_n(4); ser_clk = 1'b1; wait_n(4); ser_clk = 1'b0;
      end
      write_frame(16'hA, 4);
      expect_word("R10 idle clocks ignored", 8'h5A);
   endtask

   task automatic t_open_frame();
      ser_en_n = 1'b0;
      wait_n(4);
      shift_bits(16'hE7, 8);
      wait_n(8);
      expect_word("R3 open frame no effect", 8'h5A);
      ser_en_n = 1'b1;
      wait_n(8);
      expect_word("R3 commit on enable rise", 8'hE7);
   endtask

   task automatic t_power_down();
      int base;
      write_frame(16'hFF, 8);
      expect_word("R4 pre power-down", 8'hFF);
      pwr_dn_n = 1'b0;
      wait_n(3);
      expect_word("R4 default in power-down", 8'h80);
      base = stb_cnt;
      write_frame(16'h3C, 8);
      expect_word("R4 write in power-down ignored", 8'h80);
      n_chk++;
      if (stb_cnt != base) begin
         n_bad++;
         $display("FAIL R9: strobes in power-down %0d exp %0d", stb_cnt - base, 0);
      end
      pwr_dn_n = 1'b1;
      wait_n(10);
      expect_word("R4 default persists after release", 8'h80);
      write_frame(16'h3C, 8);
      expect_word("R4 write after release", 8'h3C);
   endtask

   initial begin
      wait_n(4);
      rst_n = 1'b1;
      t_reset();
      t_tx_select();
      t_routes();
      t_atten();
      t_unused_bit();
      t_strobe();
      t_overlong();
      t_idle_clocks();
      t_open_frame();
      t_power_down();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, got hang exp completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule